// File: doc/BRIEF.md
# Bus Width Access Splitter

This block sits between a CPU load/store port and an external data bus whose width changes from area to area. For each CPU access it takes the address, the access size (byte, word or longword), the direction, the write data and the bus width that the area decoder found for that address. It then issues as many bus cycles as that width needs. On writes it places each piece of data on the correct byte lanes. On reads it collects the returned pieces into one right-aligned result, and it reports a single completion back to the CPU.

The CPU side is a valid/ready request channel. `cpu_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where both `cpu_valid` and `cpu_ready` are high. The completion comes back as a one-cycle `cpu_done` pulse carrying `cpu_rdata` and `cpu_err`; the CPU cannot stall it. The bus side is a req/ack channel. `bus_req` stays high, with address, strobes and write data frozen, until the bus raises `bus_ack`, so a slow bus can apply back-pressure for as long as it needs. Strobe shaping and wait states are left to the bus controller. Accesses are expected to be naturally aligned.

Encodings: `cpu_size` is 0 for byte, 1 for word and 2 for longword. `cpu_width` is 0 for an 8-bit bus, 1 for 16-bit and 2 for 32-bit. Lane 0 is `bus_wdata[7:0]`, and `bus_be[i]` enables lane i. The bus is big-endian: on a bus that is W bytes wide, the byte at address offset o (address mod W) travels on lane W-1-o.

Top module: `bus_split_seq`

## Requirements
- R1: `cpu_ready` is high only in idle. A request is accepted only when `cpu_valid` and `cpu_ready` are high together, and `cpu_ready` stays low from acceptance until after the completion pulse.
- R2: The number of bus cycles is the access size divided by the bus width, with a minimum of one. A word or longword on a 16-bit bus (size 1 or 2, width 1) needs 1 or 2 cycles, a word or longword on an 8-bit bus needs 2 or 4 cycles, and any size on a 32-bit bus (width 2) needs 1 cycle.
- R3: Sub-cycles move the most significant part first, at the access address. Each following sub-cycle's address is higher by the number of bytes moved per cycle.
- R4: On an 8-bit bus every cycle uses only lane 0 (`bus_be`=4'b0001, data on bits 7:0).
- R5: On a 16-bit bus a word uses lanes 1:0 (`bus_be`=4'b0011). A byte at an even address uses lane 1 (4'b0010, bits 15:8), and a byte at an odd address uses lane 0 (4'b0001).
- R6: On a 32-bit bus a longword uses all four lanes (4'b1111). A word at offset 0 uses lanes 3:2 and at offset 2 uses lanes 1:0. A byte at offset o uses lane 3-o.
- R7: During a write cycle, every `bus_wdata` lane whose `bus_be` bit is low is zero. During a read cycle, `bus_wdata` is zero.
- R8: A read returns the assembled value right-aligned in `cpu_rdata`: the byte from the lowest address is the most significant, and lanes without an enable are ignored.
- R9: `cpu_done` pulses for exactly one cycle, in the cycle after the edge where the last sub-cycle's `bus_ack` is sampled, and `bus_req` is low in that cycle.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_addr`, `bus_be` and `bus_wdata` hold their values into the next cycle.
- R11: A longword (size 2) to an 8-bit bus (width 0) with `cpu_periph` high issues no bus cycle. It completes in the cycle after acceptance with `cpu_err` high. A longword to a 16-bit peripheral area is carried out normally.
- R12: A reserved encoding (`cpu_size`=3 or `cpu_width`=3) issues no bus cycle and completes in the cycle after acceptance with `cpu_err` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Sequencer idle, request can be taken |
| cpu_addr | input | ADDR_W | Access address |
| cpu_size | input | 2 | 0 byte, 1 word, 2 longword |
| cpu_write | input | 1 | 1 write, 0 read |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_width | input | 2 | Area bus width: 0 8-bit, 1 16-bit, 2 32-bit |
| cpu_periph | input | 1 | Target is on-chip peripheral space |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Access rejected, valid with cpu_done |
| cpu_rdata | output | 32 | Assembled read data, valid with cpu_done |
| bus_req | output | 1 | Bus cycle request |
| bus_ack | input | 1 | Bus accepts/finishes the current cycle |
| bus_addr | output | ADDR_W | Sub-cycle address |
| bus_write | output | 1 | Sub-cycle direction |
| bus_wdata | output | 32 | Lane-placed write data |
| bus_be | output | 4 | Lane enables |
| bus_rdata | input | 32 | Read data from the bus lanes |

## Verification
The bench covers every size on every width and checks the lane pattern on both sides of each bus. It fills the lanes without an enable with a junk byte on reads, so a splitter that merges the wrong lanes, or shifts by the wrong amount, returns a corrupted value. It holds `bus_ack` low for several cycles, which exposes a sequencer that advances its address or data early, or that counts a sub-cycle twice. The rejected cases (a longword to an 8-bit peripheral area, and the reserved codes) check that no bus request appears at all, and the legal longword to a 16-bit peripheral area checks that the rejection is not too broad.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_RSV = 2'd3} size_e;
  typedef enum logic [1:0] {BW_8 = 2'd0, BW_16 = 2'd1, BW_32 = 2'd2, BW_RSV = 2'd3} bw_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_RESP = 2'd2} st_e;

  // byte count of a 2-bit size/width code, 0 for the reserved code
  function automatic logic [2:0] code_bytes(input logic [1:0] code);
    case (code)
      2'd0:    code_bytes = 3'd1;
      2'd1:    code_bytes = 3'd2;
      2'd2:    code_bytes = 3'd4;
      default: code_bytes = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bsplit_plan.sv
module bsplit_plan
  import bsplit_pkg::*;
(
  input  logic [1:0] size,
  input  logic [1:0] width,
  input  logic       periph,
  output logic [2:0] n_chunks,
  output logic [2:0] chunk_bytes,
  output logic [2:0] bus_bytes,
  output logic [2:0] acc_bytes,
  output logic       reject
);
  logic [2:0] sb, wb;

  always_comb begin
    sb = code_bytes(size);
    wb = code_bytes(width);
    reject = (sb == 3'd0) || (wb == 3'd0) ||
             (size == SZ_LONG && width == BW_8 && periph);
    chunk_bytes = (sb < wb) ? sb : wb;
    bus_bytes   = wb;
    acc_bytes   = sb;
    if (sb <= wb)                        n_chunks = 3'd1;
    else if (sb == 3'd4 && wb == 3'd1)   n_chunks = 3'd4;
    else                                 n_chunks = 3'd2;
  end
endmodule

// File: rtl/bsplit_lane.sv
module bsplit_lane #(
  parameter int LANES = 4,
  localparam int DW = 8 * LANES
) (
  input  logic [2:0]    bus_bytes,
  input  logic [2:0]    chunk_bytes,
  input  logic [1:0]    offset,
  input  logic          wr,
  input  logic [DW-1:0] wchunk,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] wlanes,
  output logic [LANES-1:0] be,
  output logic [DW-1:0] rchunk
);
  logic [2:0]      lane_lo;
  logic [LANES-1:0] cmask;
  logic [DW-1:0]   dmask;
  logic [5:0]      bit_sh;

  always_comb begin
    lane_lo = bus_bytes - chunk_bytes - {1'b0, offset & bus_bytes[1:0] - 2'd1 & offset};
    case (chunk_bytes)
      3'd1:    cmask = LANES'(4'b0001);
      3'd2:    cmask = LANES'(4'b0011);
      default: cmask = LANES'(4'b1111);
    endcase
    be     = cmask << lane_lo;
    bit_sh = {lane_lo, 3'b000};
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign dmask[8*l +: 8] = {8{be[l]}};
  end

  assign wlanes = wr ? ((wchunk << bit_sh) & dmask) : '0;
  assign rchunk = (rdata & dmask) >> bit_sh;
endmodule

// File: rtl/bus_split_seq.sv
module bus_split_seq
  import bsplit_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic              cpu_write,
  input  logic [31:0]       cpu_wdata,
  input  logic [1:0]        cpu_width,
  input  logic              cpu_periph,
  output logic              cpu_done,
  output logic              cpu_err,
  output logic [31:0]       cpu_rdata,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [31:0]       bus_wdata,
  output logic [3:0]        bus_be,
  input  logic [31:0]       bus_rdata
);
  localparam int LANES = 4;

  st_e              st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]      wsh_q, acc_q;
  logic [2:0]       left_q, cb_q, bb_q;
  logic             err_q, wr_q;

  logic [2:0] p_n, p_cb, p_bb, p_sb;
  logic       p_rej;
  logic [31:0] wchunk, rchunk;
  logic [5:0]  cb_bits, pre_sh;
  logic        take, step;

  bsplit_plan u_plan (
    .size(cpu_size), .width(cpu_width), .periph(cpu_periph),
    .n_chunks(p_n), .chunk_bytes(p_cb), .bus_bytes(p_bb),
    .acc_bytes(p_sb), .reject(p_rej)
  );

  assign cb_bits = {cb_q, 3'b000};
  assign pre_sh  = 6'd32 - {p_sb, 3'b000};
  assign wchunk  = wsh_q >> (6'd32 - cb_bits);

  bsplit_lane #(.LANES(LANES)) u_lane (
    .bus_bytes(bb_q), .chunk_bytes(cb_q), .offset(addr_q[1:0]), .wr(wr_q),
    .wchunk(wchunk), .rdata(bus_rdata),
    .wlanes(bus_wdata), .be(bus_be), .rchunk(rchunk)
  );

  assign take = (st_q == ST_IDLE) && cpu_valid;
  assign step = (st_q == ST_RUN) && bus_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      wsh_q  <= '0;
      acc_q  <= '0;
      left_q <= '0;
      cb_q   <= 3'd1;
      bb_q   <= 3'd1;
      err_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (take) begin
          acc_q <= '0;
          err_q <= p_rej;
          wr_q  <= cpu_write & ~p_rej;
          if (p_rej) begin
            st_q <= ST_RESP;
          end else begin
            st_q   <= ST_RUN;
            addr_q <= cpu_addr;
            wsh_q  <= cpu_wdata << pre_sh;
            left_q <= p_n;
            cb_q   <= p_cb;
            bb_q   <= p_bb;
          end
        end
        ST_RUN: if (step) begin
          acc_q  <= (acc_q << cb_bits) | rchunk;
          wsh_q  <= wsh_q << cb_bits;
          addr_q <= addr_q + ADDR_W'(cb_q);
          left_q <= left_q - 3'd1;
          if (left_q == 3'd1) st_q <= ST_RESP;
        end
        default: begin
          st_q  <= ST_IDLE;
          wr_q  <= 1'b0;
        end
      endcase
    end
  end

  assign cpu_ready = (st_q == ST_IDLE);
  assign cpu_done  = (st_q == ST_RESP);
  assign cpu_err   = (st_q == ST_RESP) && err_q;
  assign cpu_rdata = acc_q;
  assign bus_req   = (st_q == ST_RUN);
  assign bus_addr  = addr_q;
  assign bus_write = wr_q;
endmodule

// File: rtl/bsplit_chk.sv
module bsplit_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              cpu_err,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic [31:0]       bus_wdata,
  input logic [3:0]        bus_be
);
  logic [31:0] be_bits;
  always_comb
    for (int l = 0; l < 4; l++) be_bits[8*l +: 8] = {8{bus_be[l]}};

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req); // R1
  AST_TAKE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready |=> !cpu_ready); // R1
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata)); // R10
  AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_wdata & ~be_bits) == 32'd0); // R7
  AST_READ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_write |-> bus_wdata == 32'd0); // R7
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> $countones(bus_be) == 1 || $countones(bus_be) == 2 || $countones(bus_be) == 4); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R9
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !bus_req); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_done); // R11
endmodule

bind bus_split_seq bsplit_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_done(cpu_done), .cpu_err(cpu_err), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_be(bus_be)
);

// File: tb/test_bus_split_seq.sv
module test_bus_split_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 28;

  typedef struct packed {
    logic [27:0] addr;
    logic [1:0]  size;
    logic [1:0]  width;
    logic        periph;
    logic        wr;
    logic [31:0] data;
    logic [1:0]  dly;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [0:NV-1] = '{
    '{28'h0000010, 2'd0, 2'd0, 1'b0, 1'b1, 32'h000000AB, 2'd0},
    '{28'h0000100, 2'd1, 2'd0, 1'b0, 1'b1, 32'h00001234, 2'd1},
    '{28'h0000200, 2'd2, 2'd0, 1'b0, 1'b0, 32'h00000000, 2'd0},
    '{28'h8000300, 2'd2, 2'd1, 1'b0, 1'b1, 32'hDEADBEEF, 2'd2},
    '{28'h0000400, 2'd1, 2'd1, 1'b0, 1'b0, 32'h00000000, 2'd0},
    '{28'h0000500, 2'd0, 2'd1, 1'b0, 1'b1, 32'h00000077, 2'd0},
    '{28'h0000501, 2'd0, 2'd1, 1'b0, 1'b0, 32'h00000000, 2'd1},
    '{28'h0000600, 2'd2, 2'd2, 1'b0, 1'b0, 32'h00000000, 2'd0},
    '{28'h0000603, 2'd0, 2'd2, 1'b0, 1'b1, 32'h0000005C, 2'd0},
    '{28'h0000602, 2'd1, 2'd2, 1'b0, 1'b1, 32'h0000A1B2, 2'd3},
    '{28'h5000010, 2'd2, 2'd0, 1'b1, 1'b1, 32'h11223344, 2'd0},
    '{28'h5000120, 2'd2, 2'd1, 1'b1, 1'b0, 32'h00000000, 2'd2},
    '{28'h0000700, 2'd3, 2'd1, 1'b0, 1'b0, 32'h00000000, 2'd0},
    '{28'h0000704, 2'd1, 2'd3, 1'b0, 1'b1, 32'h00005555, 2'd0},
    '{28'h0000810, 2'd2, 2'd0, 1'b0, 1'b1, 32'hCAFEF00D, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0, cpu_periph = 1'b0, bus_ack = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [1:0] cpu_size = '0, cpu_width = '0;
  logic [31:0] cpu_wdata = '0, bus_rdata = '0;
  logic cpu_ready, cpu_done, cpu_err, bus_req, bus_write;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, cpu_rdata;
  logic [3:0] bus_be;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_split_seq #(.ADDR_W(AW)) i_bus_split_seq (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_write(cpu_write),
    .cpu_wdata(cpu_wdata), .cpu_width(cpu_width), .cpu_periph(cpu_periph),
    .cpu_done(cpu_done), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return {a[3:0], a[7:4]} ^ 8'hA5;
  endfunction

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 0;
  endfunction

  task automatic run_access(input vec_t v);
    int sb, wb, c, n;
    bit rej;
    string lane_req;
    logic [31:0] res;
    logic [AW-1:0] hold_addr;
    sb = nbytes(v.size);
    wb = nbytes(v.width);
    rej = (sb == 0) || (wb == 0) || (v.size == 2'd2 && v.width == 2'd0 && v.periph);
    c = (sb < wb) ? sb : wb;
    n = rej ? 0 : sb / c;
    lane_req = (v.width == 2'd0) ? "R4" : (v.width == 2'd1) ? "R5" : "R6";
    res = '0;

    @(negedge clk);
    check(cpu_ready === 1'b1, "R1 ready before request", 64'(cpu_ready), 64'd1);
    cpu_valid = 1'b1; cpu_addr = v.addr; cpu_size = v.size; cpu_width = v.width;
    cpu_periph = v.periph; cpu_write = v.wr; cpu_wdata = v.data;
    @(negedge clk);
    cpu_valid = 1'b0;

    if (rej) begin
      // R11 R12: rejected without any bus cycle
      check(cpu_done === 1'b1 && cpu_err === 1'b1, (v.size == 2'd3 || v.width == 2'd3) ? "R12 err done" : "R11 err done",
            64'({cpu_done, cpu_err}), 64'h3);
      check(bus_req === 1'b0, "R11 no bus cycle", 64'(bus_req), 64'd0);
    end else begin
      for (int k = 0; k < n; k++) begin
        logic [3:0] ebe;
        logic [31:0] ewd, rd;
        ebe = '0; ewd = '0; rd = 32'hEEEEEEEE;
        for (int i = 0; i < c; i++) begin
          logic [AW-1:0] a;
          int lane, j;
          a = v.addr + AW'(k*c + i);
          lane = wb - 1 - int'(a % AW'(wb));
          j = k*c + i;
          ebe[lane] = 1'b1;
          ewd[8*lane +: 8] = v.wr ? 8'(v.data >> (8*(sb-1-j))) : 8'h00;
          rd[8*lane +: 8] = pat(a);
          res = (res << 8) | 32'(pat(a));
        end
        check(bus_req === 1'b1, "R2 sub-cycle requested", 64'(bus_req), 64'd1);
        if (k == 0) check(cpu_ready === 1'b0, "R1 busy not ready", 64'(cpu_ready), 64'd0);
        hold_addr = bus_addr;
        for (int d = 0; d < int'(v.dly); d++) begin
          @(negedge clk);
          check(bus_req === 1'b1 && bus_addr === hold_addr, "R10 held under back-pressure",
                64'(bus_addr), 64'(hold_addr));
        end
        check(bus_addr === v.addr + AW'(k*c), "R3 sub-cycle address", 64'(bus_addr), 64'(v.addr + AW'(k*c)));
        check(bus_be === ebe, lane_req, 64'(bus_be), 64'(ebe));
        check(bus_wdata === ewd, "R7 lane data", 64'(bus_wdata), 64'(ewd));
        bus_rdata = rd; bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0; bus_rdata = '0;
      end
      check(cpu_done === 1'b1 && cpu_err === 1'b0 && bus_req === 1'b0, "R9 R2 done after last ack",
            64'({cpu_done, cpu_err, bus_req}), 64'h4);
      if (!v.wr) check(cpu_rdata === res, "R8 assembled read", 64'(cpu_rdata), 64'(res));
    end
    @(negedge clk);
    check(cpu_done === 1'b0 && cpu_ready === 1'b1 && bus_req === 1'b0, "R9 single pulse, R1 idle again",
          64'({cpu_done, cpu_ready, bus_req}), 64'h2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cpu_ready === 1'b1 && bus_req === 1'b0 && cpu_done === 1'b0, "R1 reset state",
          64'({cpu_ready, bus_req, cpu_done}), 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready === 1'b1 && bus_req === 1'b0, "R1 after reset", 64'({cpu_ready, bus_req}), 64'h2);

    for (int i = 0; i < NV; i++) run_access(VECS[i]);

    // R1: valid held while busy must not start a second access
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = 28'h0000900; cpu_size = 2'd1; cpu_width = 2'd0;
    cpu_periph = 1'b0; cpu_write = 1'b0;
    @(negedge clk);
    cpu_addr = 28'h0000A00;
    check(bus_req === 1'b1 && bus_addr === 28'h0000900, "R1 first taken", 64'(bus_addr), 64'h900);
    bus_ack = 1'b1; bus_rdata = 32'h1;
    @(negedge clk);
    check(bus_addr === 28'h0000901, "R1 not replaced while busy", 64'(bus_addr), 64'h901);
    cpu_valid = 1'b0;
    @(negedge clk);
    bus_ack = 1'b0;
    check(cpu_done === 1'b1 && cpu_rdata === 32'h0101, "R8 back-to-back read", 64'(cpu_rdata), 64'h0101);
    @(negedge clk);
    check(bus_req === 1'b0 && cpu_ready === 1'b1, "R1 no extra access", 64'({bus_req, cpu_ready}), 64'h1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule